// File: doc/BRIEF.md
# Multi-Mode Parallel Port Router

This block takes a 32-bit pin bus plus a 4-bit function-select code and decides, word by word, what the bus means. The pins are sampled on the synchronization clock. The sampled code then routes the bus in one of three ways:

- as a register-access port that writes and reads a small 16-bit register file;
- as a pass-through of five lines to an external serial-interface engine;
- as a direct injection path that loads byte segments into staged frequency, phase and amplitude words.

The staged synthesizer parameters reach the outputs only when the update strobe is sampled high. The synthesizer core and the serial protocol engine sit outside this block. The router only decodes, routes, stages and commits.

Top module: `pport_router`

## Requirements
- R1: While `rst_n` is low and after its release, `mode_o` is 0 (no mode) and `rd_valid` is 0. `freq_word`, `phase_word`, `amp_word` and every register and staged byte are 0.
- R2: Pins are captured on a rising clock edge. No output reacts to a pin value before the edge that captures it.
- R3: `mode_o` shows the mode of the last captured code, from the edge that captures it: 1 = parallel (code 0000), 2 = serial (0001), 3 = direct (0010 to 1101), 0 = codes 1110 and 1111.
- R4: In parallel mode, control bits [2:0] are decoded as follows: bit 0 = write, bit 1 = read, bit 2 = 16-bit width. The address is bits 15:8. A 16-bit write stores bits 31:16 into the addressed register one edge after capture.
- R5: A write with bit 2 low stores bits 23:16 into the low byte of the addressed register only. The high byte keeps its value.
- R6: A read drives the addressed register onto `rd_data` with `rd_valid` high for one cycle, one edge after capture.
- R7: A control field with both read and write set performs no write and raises no `rd_valid`.
- R8: Addresses at or above 16 (the register count) are not stored on write. A read of such an address returns 0.
- R9: In serial mode, `ser_pins` equals captured bits 4:0 from the capturing edge, and all other bus bits are ignored. Outside serial mode `ser_pins` is 0.
- R10: A direct code writes the four bus bytes (lane 3 = bits 31:24 down to lane 0 = bits 7:0) into staged bytes one edge after capture. The lanes for each code are listed in the order lane 3, lane 2, lane 1, lane 0, where Fn is frequency byte n, Pn is phase byte n, An is amplitude byte n and "-" means the lane is not used. Staged bytes not named by the code keep their value.
  - 0010: F3 F2 F1 F0
  - 0011: F3 F2 P1 P0
  - 0100: F3 F2 A1 A0
  - 0101: F1 F0 P1 P0
  - 0110: F1 F0 A1 A0
  - 0111: P1 P0 A1 A0
  - 1000: F3 F2 - -
  - 1001: F1 F0 - -
  - 1010: P1 P0 - -
  - 1011: A1 A0 - -
  - 1100: P1 P0 F1 F0
  - 1101: A1 A0 F3 F2
- R11: `amp_word` carries only staged amplitude bits 11:0. Amplitude bits 15:12 have no effect on any output.
- R12: The staged words are copied to `freq_word`, `phase_word` and `amp_word` one edge after the strobe is captured high, using the staged values held before that edge. The outputs do not change otherwise.
- R13: Codes 1110 and 1111 change no register and no staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronization clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_sel | input | 4 | Function-select code |
| pin_bus | input | 32 | Multiplexed pin bus |
| upd_strobe | input | 1 | Commit request for staged parameters |
| mode_o | output | 2 | Mode of last captured code |
| ser_pins | output | 5 | Lines passed to the serial engine |
| rd_data | output | 16 | Register readback |
| rd_valid | output | 1 | Readback qualifier, one cycle |
| freq_word | output | 32 | Committed frequency word |
| phase_word | output | 16 | Committed phase word |
| amp_word | output | 12 | Committed amplitude |

## Verification
The assertions assume that the pins and the strobe change only away from the rising edge. They also assume that a read is judged on the mode captured in the cycle before `rd_valid`. The stimulus drives every pin on the falling edge and holds each word for exactly one cycle. Between commands it inserts idle words with code 1111, so that no capture overlaps the staging of the word before it. Serial and direct commands are never mixed into the same word as a parallel read.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_PAR  = 2'd1,
    MODE_SER  = 2'd2,
    MODE_DIR  = 2'd3
  } mode_t;

  // staged byte index: 0..3 freq, 4..5 phase, 6..7 amplitude; 8 = unused lane
  localparam int unsigned STG_BYTES = 8;
  localparam logic [3:0] DST_NONE = 4'd8;

  function automatic mode_t classify(input logic vld, input logic [3:0] code);
    if (!vld)                return MODE_NONE;
    else if (code == 4'b0000) return MODE_PAR;
    else if (code == 4'b0001) return MODE_SER;
    else if (code >= 4'b1110) return MODE_NONE;
    else                      return MODE_DIR;
  endfunction

  // destination pair for lanes {3,2} (hi) or {1,0} (lo): returns upper-byte index
  // of a 16-bit half; lower byte is index-1. DST_NONE when unused.
  function automatic logic [3:0] half_dest(input logic [3:0] code, input logic hi);
    logic [7:0] pair;
    case (code)
      4'b0010: pair = {4'd3, 4'd1};
      4'b0011: pair = {4'd3, 4'd5};
      4'b0100: pair = {4'd3, 4'd7};
      4'b0101: pair = {4'd1, 4'd5};
      4'b0110: pair = {4'd1, 4'd7};
      4'b0111: pair = {4'd5, 4'd7};
      4'b1000: pair = {4'd3, DST_NONE};
      4'b1001: pair = {4'd1, DST_NONE};
      4'b1010: pair = {4'd5, DST_NONE};
      4'b1011: pair = {4'd7, DST_NONE};
      4'b1100: pair = {4'd5, 4'd1};
      4'b1101: pair = {4'd7, 4'd3};
      default: pair = {DST_NONE, DST_NONE};
    endcase
    return hi ? pair[7:4] : pair[3:0];
  endfunction

  function automatic logic [3:0] lane_dest(input logic [3:0] code, input int unsigned lane);
    logic [3:0] top;
    top = half_dest(code, lane >= 2);
    if (top == DST_NONE) return DST_NONE;
    return (lane % 2 == 1) ? top : top - 4'd1;
  endfunction
endpackage

// File: rtl/pport_sampler.sv
module pport_sampler #(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned FN_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FN_W-1:0]  fn_in,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             upd_in,
  output logic             s_vld,
  output logic [FN_W-1:0]  s_fn,
  output logic [BUS_W-1:0] s_bus,
  output logic             s_upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld <= 1'b0;
      s_fn  <= '0;
      s_bus <= '0;
      s_upd <= 1'b0;
    end else begin
      s_vld <= 1'b1;
      s_fn  <= fn_in;
      s_bus <= bus_in;
      s_upd <= upd_in;
    end
  end
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile #(
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wide,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic in_range;

  assign in_range = (32'(addr) < REG_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= in_range ? regs[addr] : '0;
      if (wr_en && in_range) begin
        if (wide) regs[addr] <= wdata;
        else      regs[addr][HALF-1:0] <= wdata[HALF-1:0];
      end
    end
  end
endmodule

// File: rtl/pport_direct.sv
module pport_direct
  import pport_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned AMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_en,
  input  logic [3:0]       code,
  input  logic [LANES*8-1:0] lanes,
  input  logic             commit,
  output logic [STG_BYTES*8-1:0] stage_flat,
  output logic [31:0]      freq_word,
  output logic [15:0]      phase_word,
  output logic [AMP_W-1:0] amp_word
);
  logic [7:0] stg [STG_BYTES];
  logic [3:0] dest [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dest[l] = lane_dest(code, l);
  end

  for (genvar b = 0; b < STG_BYTES; b++) begin : g_flat
    assign stage_flat[b*8 +: 8] = stg[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < STG_BYTES; b++) stg[b] <= '0;
    end else if (dir_en) begin
      for (int l = 0; l < LANES; l++)
        if (dest[l] != DST_NONE) stg[dest[l][2:0]] <= lanes[l*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_word  <= '0;
      phase_word <= '0;
      amp_word   <= '0;
    end else if (commit) begin
      freq_word  <= stage_flat[31:0];
      phase_word <= stage_flat[47:32];
      amp_word   <= stage_flat[48 +: AMP_W];
    end
  end
endmodule

// File: rtl/pport_router.sv
module pport_router
  import pport_pkg::*;
#(
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned AMP_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  fn_sel,
  input  logic [31:0] pin_bus,
  input  logic        upd_strobe,
  output logic [1:0]  mode_o,
  output logic [4:0]  ser_pins,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic [31:0] freq_word,
  output logic [15:0] phase_word,
  output logic [AMP_W-1:0] amp_word
);
  logic        s_vld, s_upd;
  logic [3:0]  s_fn;
  logic [31:0] s_bus;
  mode_t       mode;

  // named internal events for the checker
  logic rd_req_w, wr_req_w, conflict_w, commit_w, unused_w, dir_w;
  logic [STG_BYTES*8-1:0] stage_w;

  pport_sampler #(.BUS_W(32), .FN_W(4)) u_smp (
    .clk(clk), .rst_n(rst_n), .fn_in(fn_sel), .bus_in(pin_bus), .upd_in(upd_strobe),
    .s_vld(s_vld), .s_fn(s_fn), .s_bus(s_bus), .s_upd(s_upd)
  );

  assign mode       = classify(s_vld, s_fn);
  assign mode_o     = mode;
  assign rd_req_w   = (mode == MODE_PAR) &&  s_bus[1] && !s_bus[0];
  assign wr_req_w   = (mode == MODE_PAR) &&  s_bus[0] && !s_bus[1];
  assign conflict_w = (mode == MODE_PAR) &&  s_bus[0] &&  s_bus[1];
  assign dir_w      = (mode == MODE_DIR);
  assign unused_w   = s_vld && (s_fn >= 4'b1110);
  assign commit_w   = s_upd;
  assign ser_pins   = (mode == MODE_SER) ? s_bus[4:0] : 5'd0;

  pport_regfile #(.REG_COUNT(REG_COUNT), .ADDR_W(8), .DATA_W(16)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req_w), .wide(s_bus[2]), .rd_en(rd_req_w),
    .addr(s_bus[15:8]), .wdata(s_bus[2] ? s_bus[31:16] : {8'd0, s_bus[23:16]}),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  pport_direct #(.LANES(4), .AMP_W(AMP_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .dir_en(dir_w), .code(s_fn), .lanes(s_bus),
    .commit(commit_w), .stage_flat(stage_w),
    .freq_word(freq_word), .phase_word(phase_word), .amp_word(amp_word)
  );
endmodule

// File: rtl/pport_router_checks.sv
module pport_router_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_o,
  input logic [4:0]  ser_pins,
  input logic        rd_valid,
  input logic        rd_req_w,
  input logic        conflict_w,
  input logic        commit_w,
  input logic        unused_w,
  input logic [63:0] stage_w,
  input logic [59:0] outs
);
  assert_rd_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_w |=> rd_valid);
  assert_rd_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mode_o) == 2'd1);
  assert_conflict_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_w |=> !rd_valid);
  assert_serial_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pins != 5'd0) |-> mode_o == 2'd2);
  assert_outputs_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> $stable(outs));
  assert_unused_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    unused_w |=> $stable(stage_w));
endmodule

bind pport_router pport_router_checks u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .ser_pins(ser_pins),
  .rd_valid(rd_valid), .rd_req_w(rd_req_w), .conflict_w(conflict_w),
  .commit_w(commit_w), .unused_w(unused_w), .stage_w(stage_w),
  .outs({freq_word, phase_word, amp_word})
);

// File: tb/pport_router_bench.sv
module pport_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fn = 4'hF;
  logic [31:0] bus = '0;
  logic        upd = 1'b0;
  logic [1:0]  mode_o;
  logic [4:0]  ser_pins;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [31:0] freq_word;
  logic [15:0] phase_word;
  logic [11:0] amp_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mreg [16];
  logic [7:0]  mstg [8];   // expected staged bytes: F0..F3, P0..P1, A0..A1
  logic [15:0] exp_q [$];

  always #2 clk = ~clk;

  pport_router u_pport_router (
    .clk(clk), .rst_n(rst_n), .fn_sel(fn), .pin_bus(bus), .upd_strobe(upd),
    .mode_o(mode_o), .ser_pins(ser_pins), .rd_data(rd_data), .rd_valid(rd_valid),
    .freq_word(freq_word), .phase_word(phase_word), .amp_word(amp_word)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] f, input logic [31:0] b, input logic u);
    fn = f; bus = b; upd = u;
    @(negedge clk);
  endtask

  task automatic idle();
    send(4'hF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input bit wide);
    send(4'b0000, {d, a, 5'd0, wide, 2'b01}, 1'b0);
    if (a < 16) begin
      if (wide) mreg[a] = d;
      else      mreg[a][7:0] = d[7:0];
    end
  endtask

  task automatic rd(input logic [7:0] a);
    exp_q.push_back(a < 16 ? mreg[a] : 16'h0);
    send(4'b0000, {16'hA5A5, a, 5'd0, 3'b010}, 1'b0);
  endtask

  // expected lane placement for each direct code, restated as byte names
  task automatic model_direct(input logic [3:0] c, input logic [31:0] b);
    string s;
    case (c)
      4'b0010: s = "F3F2F1F0"; 4'b0011: s = "F3F2P1P0";
      4'b0100: s = "F3F2A1A0"; 4'b0101: s = "F1F0P1P0";
      4'b0110: s = "F1F0A1A0"; 4'b0111: s = "P1P0A1A0";
      4'b1000: s = "F3F2----"; 4'b1001: s = "F1F0----";
      4'b1010: s = "P1P0----"; 4'b1011: s = "A1A0----";
      4'b1100: s = "P1P0F1F0"; 4'b1101: s = "A1A0F3F2";
      default: s = "--------";
    endcase
    for (int l = 0; l < 4; l++) begin
      byte k; byte n; int base;
      k = s[(3 - l) * 2]; n = s[(3 - l) * 2 + 1];
      base = (k == "F") ? 0 : (k == "P") ? 4 : (k == "A") ? 6 : -1;
      if (base >= 0) mstg[base + (n - "0")] = b[l*8 +: 8];
    end
  endtask

  task automatic direct(input logic [3:0] c, input logic [31:0] b);
    send(c, b, 1'b0);
    model_direct(c, b);
  endtask

  task automatic commit_and_check(input string req);
    send(4'hF, 32'h0, 1'b1);
    idle();
    idle();
    chk({req, " freq"},  freq_word,  {mstg[3], mstg[2], mstg[1], mstg[0]});
    chk({req, " phase"}, phase_word, {mstg[5], mstg[4]});
    chk({req, " amp"},   amp_word,   {mstg[7][3:0], mstg[6]});
  endtask

  // scoreboard monitor for readback
  always @(negedge clk) begin
    if (rst_n && rd_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7: actual rd_valid=1 data %0h expected no readback", rd_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL R6: actual %0h expected %0h", rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mreg[i] = '0;
    for (int i = 0; i < 8; i++) mstg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 2'd0);
    chk("R1 rd_valid", rd_valid, 1'b0);
    chk("R1 outputs", {freq_word, phase_word, amp_word}, 60'd0);
    rst_n = 1'b1;
    idle();
    chk("R3 unused code mode", mode_o, 2'd0);

    // R2 / R9 serial pass-through
    fn = 4'b0001; bus = 32'hFFFF_FFF5; upd = 1'b0;
    #1;
    chk("R2 before capture", ser_pins, 5'd0);
    @(negedge clk);
    chk("R3 serial mode", mode_o, 2'd2);
    chk("R9 serial pins", ser_pins, 5'h15);
    send(4'b0001, 32'hABCD_EF0A, 1'b0);
    chk("R9 upper bits ignored", ser_pins, 5'h0A);
    idle();
    chk("R9 quiet outside serial", ser_pins, 5'd0);

    // R4 / R5 / R6 register access
    wr(8'd3, 16'hBEEF, 1'b1);
    chk("R3 parallel mode", mode_o, 2'd1);
    idle();
    rd(8'd3);
    idle();
    wr(8'd3, 16'h1234, 1'b0);
    idle();
    rd(8'd3);
    idle();
    wr(8'd15, 16'hCAFE, 1'b1);
    wr(8'd0, 16'h7788, 1'b0);
    rd(8'd15);
    rd(8'd0);
    idle();
    idle();
    chk("R6 reads all returned", exp_q.size(), 0);

    // R7 conflicting control: no write, no readback
    send(4'b0000, {16'h5555, 8'd3, 5'd0, 3'b111}, 1'b0);
    idle();
    idle();
    rd(8'd3);
    idle(); idle();

    // R8 out-of-range address
    wr(8'd16, 16'hDEAD, 1'b1);
    wr(8'd200, 16'hDEAD, 1'b1);
    rd(8'd16);
    rd(8'd0);
    idle(); idle();
    chk("R8 reads all returned", exp_q.size(), 0);

    // R10 / R12 direct staging and commit
    direct(4'b0010, 32'h1122_3344);
    idle();
    chk("R12 no commit without strobe", freq_word, 32'd0);
    commit_and_check("R10 code0010");
    direct(4'b0011, 32'hAABB_CCDD);
    idle();
    commit_and_check("R10 code0011");
    direct(4'b0100, 32'h0102_F3F4);
    idle();
    commit_and_check("R11 code0100");
    chk("R11 amp low bits", amp_word, 12'h3F4);
    for (int c = 5; c <= 13; c++) begin
      direct(4'(c), 32'h10203040 + 32'(c) * 32'h0101_0101);
      idle();
    end
    commit_and_check("R10 codes0101to1101");

    // R13 unused codes do nothing
    send(4'b1110, 32'h9999_9999, 1'b0);
    send(4'b1111, 32'h6666_6666, 1'b0);
    send(4'b1110, {16'hFFFF, 8'd1, 8'h05}, 1'b0);
    idle();
    commit_and_check("R13 unused codes");
    rd(8'd1);
    idle(); idle();
    chk("R13 regs untouched", exp_q.size(), 0);

    // R12 strobe in same word as staging commits the previous staged values
    send(4'b1011, 32'hFFFF_0ABC, 1'b1);
    idle();
    idle();
    chk("R12 commit uses prior stage", amp_word, {mstg[7][3:0], mstg[6]});
    model_direct(4'b1011, 32'hFFFF_0ABC);
    commit_and_check("R12 later commit");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule